// File: doc/BRIEF.md
# Oscillator Timing Chain with Snapshot Event Timer

This block sits directly on the 12 MHz oscillator. It divides that clock by three into a 4 MHz processor clock. It also keeps two free-running time bases derived from a shared 0.1 ms tick.

The first time base is a 16-bit event timer that advances once per tick and wraps every 6.5536 s. The processor pulses a capture strobe to copy the running count into a holding register, and the count keeps running while it does so. Software then reads the holding register one byte at a time through a byte-select input. Both bytes come from the same snapshot, so the low and high halves always match.

The second time base counts ticks and raises an interrupt request every 0.5 ms. The request stays up until the processor acknowledges it. A period that ends while a request is still unacknowledged is flagged as an overrun.

All control inputs are synchronous to the oscillator clock. Inputs whose names end in `_ni` are active low; every other signal is active high.

Top module: `tmr_chain`

## Requirements
- R1: `cpu_clk_o` is driven straight from a flop. It repeats a high-for-one, low-for-two pattern in oscillator cycles. It is low through reset and first goes high after the third rising oscillator edge following reset release.
- R2: The event timer advances by exactly one every PRESCALE oscillator cycles, with a default of 1200 (0.1 ms at 12 MHz). After k oscillator edges since reset release, it holds floor(k/PRESCALE) modulo 2^16.
- R3: The event timer wraps from 16'hFFFF to 16'h0000 and keeps counting.
- R4: A high `cap_i` at a clock edge loads the holding register with the timer value present before that edge. When a timer step falls on the same edge, the holding register takes the pre-step value and the timer still steps. Without `cap_i`, the holding register is unchanged.
- R5: `rd_data_o` shows byte `byte_sel_i` of the holding register: select 0 gives bits 7:0 and select 1 gives bits 15:8. Both bytes stay stable until the next capture.
- R6: `irq_o` rises every IRQ_TICKS timer ticks (default 5, i.e. 6000 oscillator cycles, 0.5 ms). The first rise follows oscillator edge PRESCALE*IRQ_TICKS after reset release.
- R7: `irq_o` stays high until an edge at which `irq_ack_i` is high, and then drops. If an interrupt period ends on that same edge, `irq_o` stays high.
- R8: `irq_ovr_o` is set when an interrupt period ends while `irq_o` is high and `irq_ack_i` is low. An edge with `irq_ack_i` high clears it.
- R9: While `rst_ni` is low, every output is 0 and all counters and the holding register are cleared. The clock divider then restarts in the phase R1 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz oscillator clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| cpu_clk_o | output | 1 | Divided processor clock |
| cap_i | input | 1 | Capture strobe, copies the running timer into the holding register |
| byte_sel_i | input | 1 | Byte select for the read port (0 low, 1 high) |
| rd_data_o | output | 8 | Selected byte of the holding register |
| irq_o | output | 1 | Pending periodic interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_ovr_o | output | 1 | Interrupt overrun flag |

## Verification
The bench reduces the prescaler to 2 cycles, so a full 16-bit wrap fits in the run.

Captures are taken in three patterns, each telling different faults apart:
- Sparse captures every seventh cycle separate a correct snapshot from a stale one.
- Captures on every cycle put many strobes on the same edge as a timer step, which exposes post-increment capture.
- Back-to-back captures across the all-ones boundary show whether the timer wraps or saturates.

The interrupt is first left unacknowledged long enough to raise overruns. It is then acknowledged continuously, so that an acknowledge lands on the same edge as a new period. Finally, a reset in mid-run checks that the divider phase and every count restart from zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OSC_DIV_DEF   = 3;
  localparam int unsigned PRESCALE_DEF  = 1200;
  localparam int unsigned IRQ_TICKS_DEF = 5;
  localparam int unsigned TIMER_W_DEF   = 16;

  // counter width able to hold 0..n-1, at least one bit
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tmr_clk_div.sv
module tmr_clk_div #(
  parameter int unsigned DIV = tmr_pkg::OSC_DIV_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic clk_o
);
  localparam int unsigned CW = tmr_pkg::cnt_w(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase_q;
  logic          clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      clk_q   <= 1'b0;
    end else begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      clk_q   <= (phase_q == LAST);
    end
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned LIMIT = tmr_pkg::PRESCALE_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = tmr_pkg::cnt_w(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int unsigned W = tmr_pkg::TIMER_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cap_i,
  output logic [W-1:0] timer_o,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] timer_q;
  logic [W-1:0] hold_q;

  // capture samples timer_q before this edge's increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timer_q <= '0;
      hold_q  <= '0;
    end else begin
      if (tick_i) timer_q <= timer_q + 1'b1;
      if (cap_i)  hold_q  <= timer_q;
    end
  end

  assign timer_o = timer_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ack_i,
  output logic pend_o,
  output logic ovr_o
);
  logic pend_q;
  logic ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (tick_i)     pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
      if (tick_i && pend_q && !ack_i) ovr_q <= 1'b1;
      else if (ack_i)                 ovr_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/tmr_chain.sv
module tmr_chain #(
  parameter int unsigned OSC_DIV   = tmr_pkg::OSC_DIV_DEF,
  parameter int unsigned PRESCALE  = tmr_pkg::PRESCALE_DEF,
  parameter int unsigned IRQ_TICKS = tmr_pkg::IRQ_TICKS_DEF,
  parameter int unsigned TIMER_W   = tmr_pkg::TIMER_W_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       cpu_clk_o,
  input  logic       cap_i,
  input  logic       byte_sel_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  input  logic       irq_ack_i,
  output logic       irq_ovr_o
);
  localparam int unsigned NBYTES = TIMER_W / 8;

  logic               tick;
  logic               irq_tick;
  logic [TIMER_W-1:0] timer_q;
  logic [TIMER_W-1:0] hold_q;
  logic [7:0]         byte_arr [NBYTES];

  tmr_clk_div #(.DIV(OSC_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clk_o (cpu_clk_o)
  );

  tmr_prescale #(.LIMIT(PRESCALE)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (1'b1),
    .tick_o(tick)
  );

  tmr_prescale #(.LIMIT(IRQ_TICKS)) u_irq_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tick),
    .tick_o(irq_tick)
  );

  tmr_capture #(.W(TIMER_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .cap_i  (cap_i),
    .timer_o(timer_q),
    .hold_o (hold_q)
  );

  tmr_irq u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(irq_tick),
    .ack_i (irq_ack_i),
    .pend_o(irq_o),
    .ovr_o (irq_ovr_o)
  );

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign byte_arr[g] = hold_q[8*g +: 8];
  end

  assign rd_data_o = byte_arr[byte_sel_i];
endmodule

// File: rtl/tmr_chain_chk.sv
module tmr_chain_chk #(
  parameter int unsigned TIMER_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cpu_clk_o,
  input logic               cap_i,
  input logic               irq_o,
  input logic               irq_ack_i,
  input logic               irq_ovr_o,
  input logic               tick,
  input logic               irq_tick,
  input logic [TIMER_W-1:0] timer_q,
  input logic [TIMER_W-1:0] hold_q
);
  p_clk_high_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_o |=> !cpu_clk_o);
  p_clk_low_two_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_clk_o) |=> !cpu_clk_o);
  p_timer_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(timer_q));
  p_timer_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> timer_q == TIMER_W'($past(timer_q) + 1'b1));
  p_cap_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> hold_q == $past(timer_q));
  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(hold_q));
  p_irq_source_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_tick));
  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);
  p_irq_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !irq_tick) |=> !irq_o);
  p_ovr_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_ovr_o) |-> irq_o && $past(irq_o));
endmodule

bind tmr_chain tmr_chain_chk #(.TIMER_W(TIMER_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cpu_clk_o(cpu_clk_o),
  .cap_i    (cap_i),
  .irq_o    (irq_o),
  .irq_ack_i(irq_ack_i),
  .irq_ovr_o(irq_ovr_o),
  .tick     (tick),
  .irq_tick (irq_tick),
  .timer_q  (timer_q),
  .hold_q   (hold_q)
);

// File: tb/tmr_chain_tb.sv
module tmr_chain_tb;
  localparam int P  = 2;
  localparam int IT = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cap_i = 1'b0;
  logic       byte_sel_i = 1'b0;
  logic       irq_ack_i = 1'b0;
  logic       cpu_clk_o;
  logic [7:0] rd_data_o;
  logic       irq_o;
  logic       irq_ovr_o;

  always #2 clk_i = ~clk_i;

  tmr_chain #(.PRESCALE(P), .IRQ_TICKS(IT)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpu_clk_o (cpu_clk_o),
    .cap_i     (cap_i),
    .byte_sel_i(byte_sel_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .irq_ack_i (irq_ack_i),
    .irq_ovr_o (irq_ovr_o)
  );

  int    checks = 0;
  int    fails = 0;
  int    n = 0;
  int    m_hold = 0;
  bit    m_pend = 0;
  bit    m_ovr = 0;
  bit    running = 0;
  string rd_tag = "R5";

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %0d expected %0d", req, what, n, act, exp);
    end
  endtask

  // behavioural reference: edges since reset, closed-form time values
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n = 0; m_hold = 0; m_pend = 0; m_ovr = 0;
    end else begin
      n++;
      if (cap_i) m_hold = ((n - 1) / P) % 65536;
      if (n % (P * IT) == 0) begin
        m_ovr  = (m_pend && !irq_ack_i) ? 1'b1 : (irq_ack_i ? 1'b0 : m_ovr);
        m_pend = 1'b1;
      end else if (irq_ack_i) begin
        m_pend = 1'b0;
        m_ovr  = 1'b0;
      end
    end
  end

  always @(posedge clk_i) begin
    #1;
    if (running && rst_ni) begin
      chk("R1", "cpu_clk_o", int'(cpu_clk_o), int'(n % 3 == 0 && n > 0));
      chk(rd_tag, "rd_data_o", int'(rd_data_o),
          byte_sel_i ? ((m_hold >> 8) & 255) : (m_hold & 255));
      chk(m_pend ? "R6" : "R7", "irq_o", int'(irq_o), int'(m_pend));
      chk("R8", "irq_ovr_o", int'(irq_ovr_o), int'(m_ovr));
    end
  end

  task automatic reset_check();
    byte_sel_i = 1'b0; #0.5;
    chk("R9", "cpu_clk_o in reset", int'(cpu_clk_o), 0);
    chk("R9", "rd low in reset", int'(rd_data_o), 0);
    chk("R9", "irq_o in reset", int'(irq_o), 0);
    chk("R9", "irq_ovr_o in reset", int'(irq_ovr_o), 0);
    byte_sel_i = 1'b1; #0.5;
    chk("R9", "rd high in reset", int'(rd_data_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    reset_check();
    @(negedge clk_i);
    rst_ni = 1'b1;
    running = 1'b1;

    // sparse captures, interrupt left pending long enough to overrun
    rd_tag = "R2";
    for (int i = 0; i < 240; i++) begin
      @(negedge clk_i);
      byte_sel_i = i[0];
      cap_i      = (i % 7 == 0);
      irq_ack_i  = (i >= 150 && i < 190);
    end

    // capture every edge, many coinciding with a timer step
    rd_tag = "R4";
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      byte_sel_i = i[1];
      cap_i      = 1'b1;
      irq_ack_i  = (i % 13 == 0);
    end
    cap_i = 1'b0;
    irq_ack_i = 1'b0;

    // run up to the 16-bit wrap, capture across it
    rd_tag = "R3";
    while (n < 131060) @(negedge clk_i);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      byte_sel_i = i[0];
      cap_i      = 1'b1;
      irq_ack_i  = (i == 20);
    end
    cap_i = 1'b0;
    irq_ack_i = 1'b0;

    // reset in mid-run
    @(negedge clk_i);
    running = 1'b0;
    rst_ni = 1'b0;
    reset_check();
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    running = 1'b1;
    rd_tag = "R9";
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      byte_sel_i = i[2];
      cap_i      = (i % 5 == 2);
    end
    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired at edge %0d: actual running expected finished", n);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule